// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block drives the entry into an interrupt or software-break service routine for an 8-bit processor with a 16-bit address bus and three maskable interrupt sources: a timer and two external request lines. On every bus cycle it samples the live request lines and drops them while the interrupt-disable flag is set. When the executing instruction signals its last bus cycle and that sample is non-empty, the block takes over the bus. It issues a fixed series of discarded reads, pushes the return address and the status byte onto a fixed stack page, updates the flags, and fetches the new program counter from the vector of the highest-priority captured source.

A break request from the instruction decoder starts a shorter form of the same sequence. It skips the first two discarded reads, marks the pushed status as a break and always uses the lowest-priority vector. The processor keeps its own program counter, stack pointer and status registers. The block reads them when it starts and hands back new values with one-cycle load strobes. One clock is one bus cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_rd`, `bus_wr` and all load strobes are low, and no bus access ever occurs while `busy` is low.
- R2: The pending set is the request vector `irq_req` registered at every clock edge and forced to zero when status bit 2 (interrupt disable) of `ps_in` is set at that edge; an instruction end with an empty pending set starts nothing.
- R3: While idle, an interrupt entry starts only in a cycle with `insn_last` high and a non-empty pending set; `busy` rises in the next cycle.
- R4: The pending set is captured when entry starts. Entry proceeds, and the vector is chosen from the captured copy, even if the request line is withdrawn during the instruction's last cycle or changes during the sequence.
- R5: An interrupt entry takes 10 bus cycles: three reads at the captured PC, a write of PC[15:8] to STACK_BASE+SP, a write of PC[7:0] to STACK_BASE+SP-1, two reads at the PC, a status write to STACK_BASE+SP-2, then reads of the vector low byte at the vector address and the high byte at the vector address plus one.
- R6: A `brk_req` pulse while idle starts a break entry of 8 bus cycles: the same sequence without the first two reads.
- R7: The pushed status byte equals the status captured at start with bit 4 (break) set for a break entry and cleared for an interrupt entry; all other bits, including bit 3 (decimal) and bit 5 (memory-transfer), are kept.
- R8: In the status-push cycle `ps_load` is high and `ps_out` is the captured status with bits 3 and 5 cleared and bit 2 set.
- R9: In each push cycle `sp_load` is high and `sp_out` is the stack pointer decremented by one, modulo 256; the stack address wraps within the page.
- R10: The vector is VEC_TIMER when pending bit 0 (timer) was captured, otherwise VEC_IRQ1 for bit 1, otherwise VEC_IRQ2 for bit 2; a break always uses VEC_IRQ2.
- R11: In the last cycle `pc_load` and `done` are high and `pc_out` is {high byte, low byte} of the vector read; `busy` is high for every cycle of the sequence and low in the next one.
- R12: `brk_req`, `insn_last`, `irq_req` and the register inputs have no effect on the sequence once it has started.
- R13: When `brk_req` and an instruction end with pending requests come together, the break entry is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 3 | Live requests: bit 0 timer, bit 1 line 1, bit 2 line 2 |
| insn_last | input | 1 | Current cycle is the last bus cycle of an instruction |
| brk_req | input | 1 | Start a break entry |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| ps_in | input | 8 | Current status register |
| bus_rdata | input | 8 | Read data from the bus |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | New program counter |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 8 | New stack pointer |
| ps_load | output | 1 | Load `ps_out` into the status register |
| ps_out | output | 8 | New status value |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | New program counter is being loaded |

## Verification
Entries are tried with random pending sets that have one, two or three sources, and each set shows whether the vector follows the priority order or just the first set bit. Random status bytes with the decimal and memory-transfer bits in all combinations tell the pushed status apart from the updated one. Random stack pointers, including zero, show whether the pushes wrap within the page. Directed cases withdraw the request in the last instruction cycle and toggle every input during the sequence, which separates a captured pending set from a live one. They also assert requests under the disable flag or without an instruction end, and raise a break together with an instruction end so that break priority is checked.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter logic [15:0] VEC_TIMER  = 16'hFFFA,
  parameter logic [15:0] VEC_IRQ1   = 16'hFFF8,
  parameter logic [15:0] VEC_IRQ2   = 16'hFFF6,
  parameter logic [15:0] STACK_BASE = 16'h2100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  irq_req,
  input  logic        insn_last,
  input  logic        brk_req,
  input  logic [15:0] pc_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  ps_in,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic        pc_load,
  output logic [15:0] pc_out,
  output logic        sp_load,
  output logic [7:0]  sp_out,
  output logic        ps_load,
  output logic [7:0]  ps_out,
  output logic        busy,
  output logic        done
);

  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_B = 4;
  localparam int FL_T = 5;
  localparam logic [7:0] CLR_MASK = ~((8'd1 << FL_D) | (8'd1 << FL_T));

  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D1, S_D2, S_PCH, S_PCL, S_D3, S_D4, S_PS, S_VL, S_VH
  } st_t;

  st_t         st;
  logic [2:0]  pend_q, cap_q;
  logic        brk_q;
  logic [15:0] pc_q;
  logic [7:0]  sp_q, ps_q, vlo_q;
  logic        go_brk, go_irq, push;
  logic [15:0] vec;

  assign go_brk = (st == S_IDLE) && brk_req;
  assign go_irq = (st == S_IDLE) && !brk_req && insn_last && (pend_q != 3'b000);
  assign push   = (st == S_PCH) || (st == S_PCL) || (st == S_PS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 3'b000;
    else        pend_q <= ps_in[FL_I] ? 3'b000 : irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  st <= go_brk ? S_D2 : (go_irq ? S_D0 : S_IDLE);
        S_D0:    st <= S_D1;
        S_D1:    st <= S_D2;
        S_D2:    st <= S_PCH;
        S_PCH:   st <= S_PCL;
        S_PCL:   st <= S_D3;
        S_D3:    st <= S_D4;
        S_D4:    st <= S_PS;
        S_PS:    st <= S_VL;
        S_VL:    st <= S_VH;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 3'b000;
      brk_q <= 1'b0;
      pc_q  <= 16'h0000;
      ps_q  <= 8'h00;
    end else if (go_brk || go_irq) begin
      cap_q <= pend_q;
      brk_q <= go_brk;
      pc_q  <= pc_in;
      ps_q  <= ps_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sp_q <= 8'h00;
    else if (go_brk || go_irq) sp_q <= sp_in;
    else if (push)             sp_q <= sp_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           vlo_q <= 8'h00;
    else if (st == S_VL)  vlo_q <= bus_rdata;
  end

  always_comb begin
    if (brk_q)         vec = VEC_IRQ2;
    else if (cap_q[0]) vec = VEC_TIMER;
    else if (cap_q[1]) vec = VEC_IRQ1;
    else               vec = VEC_IRQ2;
  end

  always_comb begin
    bus_addr  = pc_q;
    bus_wdata = 8'h00;
    case (st)
      S_PCH: begin
        bus_addr  = STACK_BASE + {8'h00, sp_q};
        bus_wdata = pc_q[15:8];
      end
      S_PCL: begin
        bus_addr  = STACK_BASE + {8'h00, sp_q};
        bus_wdata = pc_q[7:0];
      end
      S_PS: begin
        bus_addr  = STACK_BASE + {8'h00, sp_q};
        bus_wdata = brk_q ? (ps_q | (8'd1 << FL_B)) : (ps_q & ~(8'd1 << FL_B));
      end
      S_VL:    bus_addr = vec;
      S_VH:    bus_addr = vec + 16'd1;
      S_IDLE:  bus_addr = 16'h0000;
      default: bus_addr = pc_q;
    endcase
  end

  assign bus_wr  = push;
  assign bus_rd  = (st != S_IDLE) && !push;
  assign sp_load = push;
  assign sp_out  = sp_q - 8'd1;
  assign ps_load = (st == S_PS);
  assign ps_out  = (ps_q & CLR_MASK) | (8'd1 << FL_I);
  assign pc_load = (st == S_VH);
  assign pc_out  = {bus_rdata, vlo_q};
  assign done    = (st == S_VH);
  assign busy    = (st != S_IDLE);

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_last,
  input logic       brk_req,
  input logic [7:0] ps_in,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       pc_load,
  input logic       sp_load,
  input logic       ps_load,
  input logic [7:0] ps_out,
  input logic       busy,
  input logic       done
);

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_rd || bus_wr || pc_load || sp_load || ps_load)); // R1

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R5

  AST_MASKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ps_in[2]) && !busy && !brk_req) |=> !busy); // R2

  AST_NO_END_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk_req && !insn_last) |=> !busy); // R3

  AST_BRK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && brk_req) |=> (busy && bus_rd)); // R6

  AST_FLAGS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_load |-> (ps_out[2] && !ps_out[3] && !ps_out[5] && bus_wr)); // R8

  AST_DONE_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_load && busy && bus_rd)); // R11

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R12

endmodule

bind irq_entry_seq irq_entry_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .insn_last(insn_last), .brk_req(brk_req),
  .ps_in(ps_in), .bus_rd(bus_rd), .bus_wr(bus_wr), .pc_load(pc_load),
  .sp_load(sp_load), .ps_load(ps_load), .ps_out(ps_out), .busy(busy),
  .done(done)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VT = 16'hFFFA, V1 = 16'hFFF8, V2 = 16'hFFF6, SB = 16'h2100;

  typedef logic [62:0] step_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  irq_req = 3'b000;
  logic        insn_last = 1'b0, brk_req = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  sp_in = 8'h00, ps_in = 8'h04;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, sp_out, ps_out;
  logic        bus_rd, bus_wr, pc_load, sp_load, ps_load, busy, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign bus_rdata = mem_f(bus_addr);

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_last(insn_last),
    .brk_req(brk_req), .pc_in(pc_in), .sp_in(sp_in), .ps_in(ps_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .pc_load(pc_load), .pc_out(pc_out),
    .sp_load(sp_load), .sp_out(sp_out), .ps_load(ps_load), .ps_out(ps_out),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R10 vector choice
  function automatic logic [15:0] exp_vec(input logic brk, input logic [2:0] cap);
    if (brk)         return V2;
    else if (cap[0]) return VT;
    else if (cap[1]) return V1;
    else             return V2;
  endfunction

  function automatic step_t pack(input logic rd, input logic wr, input logic [15:0] a,
      input logic [7:0] wd, input logic spl, input logic [7:0] spo, input logic psl,
      input logic [7:0] pso, input logic pcl, input logic [15:0] pco, input logic dn,
      input logic bz);
    return {rd, wr, a, wr ? wd : 8'h00, spl, spl ? spo : 8'h00, psl, psl ? pso : 8'h00,
            pcl, pcl ? pco : 16'h0000, dn, bz};
  endfunction

  function automatic step_t exp_step(input logic brk, input logic [2:0] cap,
      input logic [7:0] ps, input logic [7:0] sp, input logic [15:0] pc, input int idx);
    logic [15:0] v;
    logic [7:0] pushed, updated;
    v = exp_vec(brk, cap);
    pushed  = brk ? (ps | 8'h10) : (ps & 8'hEF);
    updated = (ps & 8'hD7) | 8'h04;
    case (idx)
      3: return pack(0, 1, SB + {8'h00, sp}, pc[15:8], 1, sp - 8'd1, 0, 0, 0, 0, 0, 1);
      4: return pack(0, 1, SB + {8'h00, 8'(sp - 8'd1)}, pc[7:0], 1, sp - 8'd2, 0, 0, 0, 0, 0, 1);
      7: return pack(0, 1, SB + {8'h00, 8'(sp - 8'd2)}, pushed, 1, sp - 8'd3, 1, updated, 0, 0, 0, 1);
      8: return pack(1, 0, v, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      9: return pack(1, 0, v + 16'd1, 0, 0, 0, 0, 0, 1, {mem_f(v + 16'd1), mem_f(v)}, 1, 1);
      default: return pack(1, 0, pc, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endcase
  endfunction

  function automatic string req_of(input logic brk, input int idx);
    case (idx)
      0, 1, 2, 5, 6: return brk ? "R6 dummy read" : "R5 dummy read";
      3, 4:          return "R9 return address push";
      7:             return "R7/R8 status push";
      8:             return "R10 vector low";
      default:       return "R11 vector high and load";
    endcase
  endfunction

  function automatic step_t actual();
    return pack(bus_rd, bus_wr, bus_addr, bus_wdata, sp_load, sp_out, ps_load, ps_out,
                pc_load, pc_out, done, busy);
  endfunction

  // brk: break entry; also_end: insn_last with pending in same cycle (R13)
  // late: withdraw request in last cycle (R4); noise: toggle inputs during sequence (R12)
  task automatic run_entry(input logic brk, input logic also_end, input logic [2:0] pend,
      input logic [7:0] ps, input logic [7:0] sp, input logic [15:0] pc,
      input logic late, input logic noise);
    @(negedge clk);
    irq_req = pend; ps_in = ps; sp_in = sp; pc_in = pc;
    @(negedge clk);
    check("R3 idle before start", {63'd0, busy}, 64'd0);
    if (brk) brk_req = 1'b1;
    if (!brk || also_end) insn_last = 1'b1;
    if (late) irq_req = 3'b000;
    @(negedge clk);
    brk_req = 1'b0; insn_last = 1'b0; irq_req = 3'b000;
    for (int i = (brk ? 2 : 0); i < 10; i++) begin
      check(req_of(brk, i), {1'b0, actual()}, {1'b0, exp_step(brk, pend, ps, sp, pc, i)});
      if (noise && i < 9) begin
        irq_req = 3'($urandom); brk_req = 1'($urandom); insn_last = 1'($urandom);
        ps_in = 8'($urandom); sp_in = 8'($urandom); pc_in = 16'($urandom);
      end else begin
        irq_req = 3'b000; brk_req = 1'b0; insn_last = 1'b0; ps_in = 8'h04;
      end
      @(negedge clk);
    end
    check("R11 busy drops after done", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {58'd0, busy, done, bus_rd, bus_wr, pc_load, sp_load}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {60'd0, busy, done, bus_rd, bus_wr}, 64'd0);

    // R2: requests under the disable flag
    ps_in = 8'h04; irq_req = 3'b111;
    @(negedge clk);
    insn_last = 1'b1;
    @(negedge clk);
    insn_last = 1'b0;
    check("R2 masked request ignored", {62'd0, busy, bus_rd}, 64'd0);
    @(negedge clk);
    check("R2 masked request stays idle", {63'd0, busy}, 64'd0);

    // R3: unmasked requests without instruction end
    ps_in = 8'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 no start without instruction end", {63'd0, busy}, 64'd0);
    end
    irq_req = 3'b000; ps_in = 8'h04;

    // directed corners
    run_entry(0, 0, 3'b001, 8'h28, 8'hFF, 16'h1234, 0, 0); // R10 timer, D/T set
    run_entry(0, 0, 3'b110, 8'hC3, 8'h80, 16'hE000, 0, 0); // R10 line 1 over line 2
    run_entry(0, 0, 3'b100, 8'h00, 8'h00, 16'h8001, 0, 0); // R9 stack wrap at zero
    run_entry(0, 0, 3'b010, 8'h20, 8'h01, 16'h4321, 1, 0); // R4 late withdraw
    run_entry(0, 0, 3'b011, 8'h09, 8'h40, 16'hFFFF, 1, 1); // R12 noise during sequence
    run_entry(1, 0, 3'b000, 8'h3C, 8'h7F, 16'h0200, 0, 0); // R6 break
    run_entry(1, 1, 3'b001, 8'h28, 8'h10, 16'hABCD, 0, 0); // R13 break wins over timer
    run_entry(1, 0, 3'b000, 8'hFF, 8'h02, 16'h0000, 0, 1); // R7 break with all flags

    for (int n = 0; n < 300; n++) begin
      logic b;
      logic [2:0] p;
      logic [7:0] s;
      b = ($urandom % 4) == 0;
      p = 3'($urandom);
      if (!b && p == 3'b000) p = 3'b100;
      s = 8'($urandom);
      if (!b) s[2] = 1'b0;
      run_entry(b, b && p != 3'b000 && (($urandom % 2) == 0), b ? 3'b000 : p, s,
                8'($urandom), 16'($urandom), !b && (($urandom % 3) == 0), ($urandom % 2) == 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule